// File: doc/BRIEF.md
# GPIO Port with Atomic Bit Aliases

A sixteen-pin general-purpose I/O port attached to a simple word-addressed 32-bit register bus. Software configures each pin through six control registers: output latch, direction, analog select, open-drain enable, pull-up enable and pull-down enable. The block turns them into registered per-pin controls for the pad: output enable, output value, open-drain flag and the two pull enables. Pad input levels come back through a two-flop synchronizer and can be read from a read-only level register.

Each register group takes 16 bytes of address space. The word at the group base reads and writes the register directly. The next three words are write-only aliases: a one bit written there clears, sets or inverts the matching register bit, and a zero bit leaves that bit alone. Software can therefore change single pins without a read-modify-write and without racing other writers.

Byte offset bits [6:4] select the group: 0 analog select, 1 direction, 2 pin levels (read-only), 3 output latch, 4 open drain, 5 pull-up, 6 pull-down. Bits [3:2] select the access: 0 base, 1 clear, 2 set, 3 invert. Reads return data on `bus_rdata` one clock after `bus_rd` is sampled high.

Top module: `gpio_alias_port`

## Requirements
- R1: After reset every direction bit and every analog-select bit is 1, and the output latch, open-drain, pull-up and pull-down registers are 0. All pad controls are 0.
- R2: A write to a group base (offset bits [3:2]=0) loads bits [15:0] of the write data into that register. A read of the base returns the register in bits [15:0], and bits [31:16] always read as 0.
- R3: A write to the clear alias (bits [3:2]=1) clears every register bit whose write-data bit is 1 and leaves the other bits unchanged.
- R4: A write to the set alias (bits [3:2]=2) sets every register bit whose write-data bit is 1 and leaves the other bits unchanged.
- R5: A write to the invert alias (bits [3:2]=3) toggles every register bit whose write-data bit is 1 and leaves the other bits unchanged.
- R6: A read of any clear, set or invert alias returns 0.
- R7: A pin drives (pad_oe=1) only when its direction bit is 0 and its analog-select bit is 0. A direction bit of 1 or an analog-select bit of 1 keeps the pin undriven.
- R8: When a driving pin has open drain set, it drives low (pad_oe=1, pad_out=0) for a latch 0 and releases (pad_oe=0) for a latch 1. A push-pull pin outputs its latch value. pad_od mirrors the open-drain register.
- R9: pad_pu and pad_pd mirror the pull-up and pull-down registers.
- R10: The pin-level register (offset 0x20) returns pad_in after a two-flop synchronizer. A pin whose analog-select bit is 1 reads 0, and writes to the pin-level group change nothing.
- R11: A write to an unmapped offset (group 7, a non-word-aligned address, or address bits above bit 7 non-zero) changes no register, and a read of one returns 0.
- R12: Pad-control outputs are registered and change one clock after the register write that causes them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| pad_in | input | 16 | Asynchronous pad input levels |
| pad_oe | output | 16 | Per-pin output enable |
| pad_out | output | 16 | Per-pin output value |
| pad_od | output | 16 | Per-pin open-drain flag |
| pad_pu | output | 16 | Per-pin pull-up enable |
| pad_pd | output | 16 | Per-pin pull-down enable |

## Verification
The bench applies clear, set and invert masks that overlap bits already at the target value. An alias implemented as a plain store, or one that touches unselected bits, produces a wrong read-back. It checks that a pin with its direction cleared still does not drive while analog select is set, and that an open-drain pin with latch 1 releases instead of driving high. It reads the level register right after pad_in changes to confirm the synchronizer delay, then sets analog select on some pins to confirm they read 0. Writes to the read-only level group and to unmapped or misaligned offsets must leave the registers unchanged, which catches decoders that alias those offsets onto real registers.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int GRP_ANSEL = 0;
  localparam int GRP_DIR   = 1;
  localparam int GRP_PIN   = 2;
  localparam int GRP_LAT   = 3;
  localparam int GRP_ODC   = 4;
  localparam int GRP_PU    = 5;
  localparam int GRP_PD    = 6;
  localparam int GRP_NONE  = 7;
  localparam int NGRP      = 8;

  typedef enum logic [1:0] {
    OP_BASE = 2'd0,
    OP_CLR  = 2'd1,
    OP_SET  = 2'd2,
    OP_INV  = 2'd3
  } alias_op_t;

  function automatic bit grp_resets_high(int g);
    return (g == GRP_ANSEL) || (g == GRP_DIR);
  endfunction
endpackage

// File: rtl/gpio_alias_reg.sv
module gpio_alias_reg #(
  parameter int W       = 16,
  parameter bit RST_ONE = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  gpio_pkg::alias_op_t op,
  input  logic [W-1:0] wd,
  output logic [W-1:0] q
);
  import gpio_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= {W{RST_ONE}};
    end else if (we) begin
      case (op)
        OP_BASE: q <= wd;
        OP_CLR:  q <= q & ~wd;
        OP_SET:  q <= q | wd;
        default: q <= q ^ wd;
      endcase
    end
  end

  // R3
  clr_alias_chk: assert property (@(posedge clk) disable iff (rst)
    (we && op == OP_CLR) |=> ((q & $past(wd)) == '0) && ((q & ~$past(wd)) == ($past(q) & ~$past(wd))));
  // R4
  set_alias_chk: assert property (@(posedge clk) disable iff (rst)
    (we && op == OP_SET) |=> ((q & $past(wd)) == $past(wd)) && ((q & ~$past(wd)) == ($past(q) & ~$past(wd))));
  // R5
  inv_alias_chk: assert property (@(posedge clk) disable iff (rst)
    (we && op == OP_INV) |=> (q == ($past(q) ^ $past(wd))));
  // R11
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(q));
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= '0;
      q  <= '0;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end

  // R10
  sync_delay_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |=> (q == $past(d, 2)));
endmodule

// File: rtl/gpio_alias_port.sv
module gpio_alias_port #(
  parameter int NPIN = 16,
  parameter int AW   = 8,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [NPIN-1:0] pad_in,
  output logic [NPIN-1:0] pad_oe,
  output logic [NPIN-1:0] pad_out,
  output logic [NPIN-1:0] pad_od,
  output logic [NPIN-1:0] pad_pu,
  output logic [NPIN-1:0] pad_pd
);
  import gpio_pkg::*;

  localparam int GW = $clog2(NGRP);

  logic [GW-1:0]   grp;
  alias_op_t       op;
  logic            hit;
  logic [NPIN-1:0] ctl [NGRP];
  logic [NPIN-1:0] lvl_sync;
  logic [NPIN-1:0] rd_val;
  logic            unused_wdata;

  assign grp          = bus_addr[6:4];
  assign op           = alias_op_t'(bus_addr[3:2]);
  assign hit          = (bus_addr[1:0] == 2'b00) && (bus_addr[AW-1:7] == '0) &&
                        (grp != GW'(GRP_NONE));
  assign unused_wdata = ^bus_wdata[DW-1:NPIN];

  gpio_in_sync #(.W(NPIN)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pad_in),
    .q   (lvl_sync)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    if (g == GRP_PIN) begin : g_lvl
      assign ctl[g] = lvl_sync & ~ctl[GRP_ANSEL];
    end else if (g == GRP_NONE) begin : g_gap
      assign ctl[g] = '0;
    end else begin : g_reg
      gpio_alias_reg #(.W(NPIN), .RST_ONE(grp_resets_high(g))) u_reg (
        .clk (clk),
        .rst (rst),
        .we  (bus_wr && hit && (grp == GW'(g))),
        .op  (op),
        .wd  (bus_wdata[NPIN-1:0]),
        .q   (ctl[g])
      );
    end
  end

  assign rd_val = (hit && op == OP_BASE) ? ctl[grp] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= DW'(rd_val);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_oe  <= '0;
      pad_out <= '0;
      pad_od  <= '0;
      pad_pu  <= '0;
      pad_pd  <= '0;
    end else begin
      pad_oe  <= ~ctl[GRP_DIR] & ~ctl[GRP_ANSEL] & ~(ctl[GRP_ODC] & ctl[GRP_LAT]);
      pad_out <= ctl[GRP_LAT] & ~ctl[GRP_ODC];
      pad_od  <= ctl[GRP_ODC];
      pad_pu  <= ctl[GRP_PU];
      pad_pd  <= ctl[GRP_PD];
    end
  end

  // R2
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[DW-1:NPIN] == '0);
  // R6
  alias_rd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && op != OP_BASE) |=> (bus_rdata == '0));
  // R11
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !hit) |=> (bus_rdata == '0));
  // R7
  analog_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ((pad_oe & $past(ctl[GRP_ANSEL])) == '0));
  // R8
  od_no_high_chk: assert property (@(posedge clk) disable iff (rst)
    ((pad_out & pad_od) == '0));
endmodule

// File: tb/sim_gpio_alias_port.sv
module sim_gpio_alias_port;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] pad_in = '0;
  logic [15:0] pad_oe, pad_out, pad_od, pad_pu, pad_pd;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  gpio_alias_port u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .pad_od(pad_od),
    .pad_pu(pad_pu), .pad_pd(pad_pd)
  );

  // {write addr, write data, read addr, expected read}
  localparam int NV = 13;
  localparam logic [79:0] VEC [NV] = '{
    {8'h30, 32'h1234_A5A5, 8'h30, 32'h0000_A5A5}, // R2 base write, upper ignored
    {8'h34, 32'h0000_00FF, 8'h30, 32'h0000_A500}, // R3
    {8'h38, 32'h0000_000F, 8'h30, 32'h0000_A50F}, // R4
    {8'h3C, 32'h0000_FFFF, 8'h30, 32'h0000_5AF0}, // R5
    {8'h14, 32'h0000_00FF, 8'h10, 32'h0000_FF00}, // R3 direction clear
    {8'h18, 32'h0000_0F00, 8'h10, 32'h0000_FF00}, // R4 set on already-one bits
    {8'h1C, 32'h0000_0003, 8'h10, 32'h0000_FF03}, // R5
    {8'h04, 32'h0000_FFFF, 8'h00, 32'h0000_0000}, // R3 analog clear
    {8'h58, 32'h0000_0011, 8'h50, 32'h0000_0011}, // R4 pull-up
    {8'h68, 32'h0000_0022, 8'h60, 32'h0000_0022}, // R4 pull-down
    {8'h48, 32'h0000_00F0, 8'h40, 32'h0000_00F0}, // R4 open drain
    {8'h70, 32'h0000_FFFF, 8'h30, 32'h0000_5AF0}, // R11 unmapped write
    {8'h31, 32'h0000_0000, 8'h30, 32'h0000_5AF0}  // R11 misaligned write
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    rd_chk("R1 analog", 8'h00, 32'h0000_FFFF);
    rd_chk("R1 dir", 8'h10, 32'h0000_FFFF);
    rd_chk("R1 latch", 8'h30, 32'h0);
    rd_chk("R1 pullup", 8'h50, 32'h0);
    chk("R1 pad_oe", {16'h0, pad_oe}, 32'h0);
    // R7 direction output but analog still selected: no drive
    wr(8'h14, 32'h0000_0001);
    @(negedge clk);
    chk("R7 analog blocks drive", {16'h0, pad_oe}, 32'h0);
    wr(8'h18, 32'h0000_0001);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][79:72], VEC[i][71:40]);
      rd_chk($sformatf("vector %0d R2-R5/R11", i), VEC[i][39:32], VEC[i][31:0]);
    end

    // R12, R7, R8, R9 pad controls (lat 5AF0 dir FF03 od 00F0)
    chk("R7 R8 pad_oe", {16'h0, pad_oe}, 32'h0000_000C);
    chk("R8 pad_out", {16'h0, pad_out}, 32'h0000_5A00);
    chk("R8 pad_od", {16'h0, pad_od}, 32'h0000_00F0);
    chk("R9 pad_pu", {16'h0, pad_pu}, 32'h0000_0011);
    chk("R9 pad_pd", {16'h0, pad_pd}, 32'h0000_0022);
    // R8 open-drain pin with latch 0 drives low
    wr(8'h34, 32'h0000_0010);
    chk("R12 pad_oe before update", {16'h0, pad_oe}, 32'h0000_000C);
    @(negedge clk);
    chk("R8 od drive low", {16'h0, pad_oe}, 32'h0000_001C);
    // R6 aliases read zero
    rd_chk("R6 clr alias", 8'h34, 32'h0);
    rd_chk("R6 set alias", 8'h18, 32'h0);
    rd_chk("R6 inv alias", 8'h0C, 32'h0);
    // R11 unmapped reads
    rd_chk("R11 group7", 8'h70, 32'h0);
    rd_chk("R11 misaligned", 8'h32, 32'h0);
    rd_chk("R11 high addr", 8'hB0, 32'h0);
    // R10 synchronized levels
    @(negedge clk);
    pad_in = 16'hABCD;
    bus_rd = 1'b1; bus_addr = 8'h20;
    @(negedge clk);
    bus_rd = 1'b0;
    chk("R10 sync delay", bus_rdata, 32'h0);
    repeat (3) @(negedge clk);
    rd_chk("R10 level", 8'h20, 32'h0000_ABCD);
    wr(8'h08, 32'h0000_000F);
    rd_chk("R10 analog reads zero", 8'h20, 32'h0000_ABC0);
    @(negedge clk);
    chk("R7 analog set stops drive", {16'h0, pad_oe}, 32'h0000_0010);
    wr(8'h24, 32'h0000_FFFF);
    wr(8'h20, 32'h0000_0000);
    rd_chk("R10 write ignored", 8'h20, 32'h0000_ABC0);
    rd_chk("R10 analog intact", 8'h00, 32'h0000_000F);
    finish_run();
  end
endmodule